// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block gathers interrupt requests from three kinds of source and hands them out to up to four CPU interfaces. The sources are software-raised inter-processor interrupts, per-CPU private timer and watchdog lines, and shared hardware lines. Every interrupt number keeps its own three-state machine for each CPU. Each machine is one of INACTIVE, PENDING or ACTIVE, and it moves by five named transitions:

- RAISE: INACTIVE to PENDING.
- WITHDRAW: PENDING to INACTIVE.
- TAKE: PENDING to ACTIVE.
- RETIRE: ACTIVE to INACTIVE.
- REPEND: ACTIVE to PENDING.

For each CPU an arbiter finds the most urgent pending interrupt. It offers that interrupt only when it is strictly more urgent than everything already active on that CPU, and this is how preemption works. A CPU pulses `ack` to take the offered ID. It later returns the same ID on `eoi`.

A one-write-per-cycle configuration port sets enables, priorities and shared-line target masks. The same port raises software interrupts. The legacy fast-interrupt inputs pass straight through to the outputs.

Top module: `irq_distributor`

## Requirements
- R1: After reset every interrupt is INACTIVE on every CPU, every `ack_id` slice reads 1023 and `irq_out` is all zero.
- R2: The ID map is fixed, and IDs outside it never become pending.
  - IDs 0–15 are software interrupts, banked per CPU.
  - ID 29 is the CPU's own `tmr_irq` bit and ID 30 is its own `wdg_irq` bit.
  - IDs 32 to 32+NHW−1 are `hw_irq[ID−32]`.
- R3: An interrupt whose enable bit is 0 never makes the RAISE transition. The enable is taken as it stood before the edge that samples the request, so an enable written in the same cycle acts one cycle later.
- R4: A level source (IDs 29, 30 and shared lines) makes RAISE while it is asserted and enabled, and WITHDRAW when it drops before being taken.
- R5: A shared line counts as asserted on CPU c only when bit c of its target mask is set. Each targeted CPU keeps its own state.
- R6: A write of kind 3 raises software interrupt `cfg_id` (0–15) on the CPUs chosen by `cfg_data[5:4]`:
  - 0: the list in `cfg_data[3:0]`, where bit c stands for CPU c.
  - 1: all CPUs except `cfg_cpu`.
  - 2: `cfg_cpu` only.
  - 3: no CPU.
  
  The request has no effect on a CPU whose copy of that ID is not INACTIVE, and it stays PENDING until taken.
- R7: A lower priority value is more urgent, and equal values go to the lower ID. A priority write to an ID below 32 changes only the bank of `cfg_cpu`. A write to an ID of 32 or above changes the value for all CPUs. A software interrupt uses the bank of the CPU that receives it.
- R8: `ack_id` slice c shows the best pending ID when its priority is strictly below CPU c's running priority, and 1023 otherwise. The running priority is the minimum priority over its ACTIVE IDs, or 16 when none is active. `irq_out[c]` is high exactly when that slice is not 1023. A pulse on `ack[c]` makes TAKE on the shown ID at that edge.
- R9: A pending interrupt preempts an active one only with a strictly lower priority value. An equal value is not offered.
- R10: A pulse on `eoi[c]` with an ID that is ACTIVE on CPU c makes REPEND if that ID is a level source that is still asserted and enabled, and RETIRE otherwise. An `eoi` naming an ID that is not ACTIVE has no effect.
- R11: `fiq_out` equals `fiq_in` in the same cycle.
- R12: Write kinds:
  - Kind 0 sets enable to `cfg_data[0]`.
  - Kind 1 sets priority to `cfg_data[3:0]`.
  - Kind 2 sets the target mask of a shared ID to `cfg_data[NCPU-1:0]`, and is ignored for IDs below 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NHW | Shared hardware lines, level |
| tmr_irq | input | NCPU | Per-CPU private timer request (ID 29) |
| wdg_irq | input | NCPU | Per-CPU private watchdog request (ID 30) |
| fiq_in | input | NCPU | Legacy fast interrupt inputs |
| fiq_out | output | NCPU | Fast interrupt pass-through |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 enable, 1 priority, 2 target, 3 software interrupt |
| cfg_cpu | input | clog2(NCPU) | Requesting CPU |
| cfg_id | input | clog2(32+NHW) | Interrupt ID addressed |
| cfg_data | input | 6 | Write data |
| ack | input | NCPU | Per-CPU acknowledge pulse |
| ack_id | output | NCPU*10 | Per-CPU offered ID, 1023 when none |
| irq_out | output | NCPU | Per-CPU interrupt request |
| eoi | input | NCPU | Per-CPU end-of-interrupt pulse |
| eoi_id | input | NCPU*10 | Per-CPU ID being completed |

## Verification
The assertions assume a few things about the inputs: `cfg_cpu` names an existing CPU, at most one configuration write arrives per cycle, and `eoi_id` may carry any ten-bit value, including IDs that are not active or are outside the map. The stimulus keeps within these limits. In its directed phase it issues writes one per cycle, and in its random phase it draws `eoi_id` from both live and unused IDs and pulses `ack` freely. This lets the properties on TAKE, RETIRE/REPEND and disabled RAISE meet both meaningful and ignored handshakes.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic [1:0] {
        ST_INACTIVE = 2'd0,
        ST_PENDING  = 2'd1,
        ST_ACTIVE   = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        WK_ENABLE = 2'd0,
        WK_PRIO   = 2'd1,
        WK_TARGET = 2'd2,
        WK_SGI    = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        SG_LIST   = 2'd0,
        SG_OTHERS = 2'd1,
        SG_SELF   = 2'd2,
        SG_NONE   = 2'd3
    } sgi_mode_e;

    localparam int ID_OUT_W    = 10;
    localparam int SPURIOUS_ID = 1023;
    localparam int SGI_COUNT   = 16;
    localparam int TIMER_ID    = 29;
    localparam int WDOG_ID     = 30;
    localparam int SHARED_BASE = 32;
endpackage

// File: rtl/irqd_cell.sv
module irqd_cell
    import irqd_pkg::*;
#(
    parameter bit LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic sgi_evt,
    input  logic enabled,
    input  logic take,
    input  logic retire,
    output logic pending,
    output logic active
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INACTIVE: begin
                if (enabled && (line || sgi_evt)) state_d = ST_PENDING;      // RAISE
            end
            ST_PENDING: begin
                if (take)               state_d = ST_ACTIVE;                // TAKE
                else if (LEVEL && !line) state_d = ST_INACTIVE;             // WITHDRAW
            end
            ST_ACTIVE: begin
                if (retire)
                    state_d = (LEVEL && line && enabled) ? ST_PENDING       // REPEND
                                                         : ST_INACTIVE;     // RETIRE
            end
            default: state_d = ST_INACTIVE;
        endcase
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
        active  = (state_q == ST_ACTIVE);
    end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NID    = 64,
    parameter int PRIO_W = 4
) (
    input  logic [NID-1:0]        pend,
    input  logic [NID-1:0]        act,
    input  logic [NID*PRIO_W-1:0] prio,
    output logic [ID_OUT_W-1:0]   offer_id,
    output logic                  offer_valid
);
    logic                 best_v;
    logic [PRIO_W-1:0]    best_p;
    logic [ID_OUT_W-1:0]  best_id;
    logic [PRIO_W:0]      run_p;
    logic [PRIO_W-1:0]    p;

    always_comb begin
        best_v  = 1'b0;
        best_p  = '0;
        best_id = '0;
        run_p   = {1'b1, {PRIO_W{1'b0}}};
        p       = '0;
        for (int i = 0; i < NID; i++) begin
            p = prio[i*PRIO_W +: PRIO_W];
            if (pend[i] && (!best_v || p < best_p)) begin
                best_v  = 1'b1;
                best_p  = p;
                best_id = ID_OUT_W'(i);
            end
            if (act[i] && ({1'b0, p} < run_p)) run_p = {1'b0, p};
        end
        offer_valid = best_v && ({1'b0, best_p} < run_p);
        offer_id    = offer_valid ? best_id : ID_OUT_W'(SPURIOUS_ID);
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NHW    = 32,
    parameter int PRIO_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NHW-1:0]                        hw_irq,
    input  logic [NCPU-1:0]                       tmr_irq,
    input  logic [NCPU-1:0]                       wdg_irq,
    input  logic [NCPU-1:0]                       fiq_in,
    output logic [NCPU-1:0]                       fiq_out,
    input  logic                                  cfg_wr,
    input  logic [1:0]                            cfg_kind,
    input  logic [$clog2(NCPU)-1:0]               cfg_cpu,
    input  logic [$clog2(SHARED_BASE+NHW)-1:0]    cfg_id,
    input  logic [5:0]                            cfg_data,
    input  logic [NCPU-1:0]                       ack,
    output logic [NCPU*ID_OUT_W-1:0]              ack_id,
    output logic [NCPU-1:0]                       irq_out,
    input  logic [NCPU-1:0]                       eoi,
    input  logic [NCPU*ID_OUT_W-1:0]              eoi_id
);
    localparam int NID   = SHARED_BASE + NHW;
    localparam int IDW   = $clog2(NID);
    localparam int CPUW  = $clog2(NCPU);
    localparam int HW_IW = (NHW > 1) ? $clog2(NHW) : 1;

    logic [NID-1:0]     en_q;
    logic [PRIO_W-1:0]  prio_q [NCPU][NID];
    logic [NCPU-1:0]    tgt_q  [NHW];

    logic [NCPU*NID-1:0] pend_all;
    logic [NCPU*NID-1:0] act_all;

    wr_kind_e           wk;
    sgi_mode_e          sg_mode;
    logic               sgi_fire;
    logic [NCPU-1:0]    sgi_dest;
    logic [NCPU-1:0]    self_mask;
    logic [HW_IW-1:0]   hw_idx;
    logic               id_shared;

    assign fiq_out = fiq_in;

    always_comb begin
        wk        = wr_kind_e'(cfg_kind);
        sg_mode   = sgi_mode_e'(cfg_data[5:4]);
        id_shared = (int'(cfg_id) >= SHARED_BASE);
        hw_idx    = HW_IW'(int'(cfg_id) - SHARED_BASE);
        self_mask = NCPU'(1) << cfg_cpu;
        sgi_fire  = cfg_wr && (wk == WK_SGI) && (int'(cfg_id) < SGI_COUNT);
        unique case (sg_mode)
            SG_LIST:   sgi_dest = cfg_data[NCPU-1:0];
            SG_OTHERS: sgi_dest = ~self_mask;
            SG_SELF:   sgi_dest = self_mask;
            default:   sgi_dest = '0;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int c = 0; c < NCPU; c++)
                for (int i = 0; i < NID; i++)
                    prio_q[c][i] <= '0;
            for (int h = 0; h < NHW; h++)
                tgt_q[h] <= '0;
        end else if (cfg_wr) begin
            unique case (wk)
                WK_ENABLE: en_q[cfg_id] <= cfg_data[0];
                WK_PRIO: begin
                    for (int c = 0; c < NCPU; c++)
                        if (id_shared || cfg_cpu == CPUW'(c))
                            prio_q[c][cfg_id] <= cfg_data[PRIO_W-1:0];
                end
                WK_TARGET: begin
                    if (id_shared) tgt_q[hw_idx] <= cfg_data[NCPU-1:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NID*PRIO_W-1:0] prio_flat;
        logic [ID_OUT_W-1:0]   offer_id;
        logic                  offer_valid;
        logic [ID_OUT_W-1:0]   done_id;

        assign done_id = eoi_id[c*ID_OUT_W +: ID_OUT_W];

        for (genvar i = 0; i < NID; i++) begin : g_id
            logic take_i, retire_i;
            assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[c][i];
            assign take_i   = ack[c] && offer_valid && (offer_id == ID_OUT_W'(i));
            assign retire_i = eoi[c] && (done_id == ID_OUT_W'(i));

            if (i < SGI_COUNT) begin : g_sgi
                irqd_cell #(.LEVEL(1'b0)) u_cell (
                    .clk(clk), .rst_n(rst_n), .line(1'b0),
                    .sgi_evt(sgi_fire && sgi_dest[c] && (cfg_id == IDW'(i))),
                    .enabled(en_q[i]), .take(take_i), .retire(retire_i),
                    .pending(pend_all[c*NID+i]), .active(act_all[c*NID+i]));
            end else if (i == TIMER_ID || i == WDOG_ID) begin : g_priv
                irqd_cell #(.LEVEL(1'b1)) u_cell (
                    .clk(clk), .rst_n(rst_n),
                    .line((i == TIMER_ID) ? tmr_irq[c] : wdg_irq[c]),
                    .sgi_evt(1'b0),
                    .enabled(en_q[i]), .take(take_i), .retire(retire_i),
                    .pending(pend_all[c*NID+i]), .active(act_all[c*NID+i]));
            end else if (i >= SHARED_BASE) begin : g_hw
                irqd_cell #(.LEVEL(1'b1)) u_cell (
                    .clk(clk), .rst_n(rst_n),
                    .line(hw_irq[i-SHARED_BASE] && tgt_q[i-SHARED_BASE][c]),
                    .sgi_evt(1'b0),
                    .enabled(en_q[i]), .take(take_i), .retire(retire_i),
                    .pending(pend_all[c*NID+i]), .active(act_all[c*NID+i]));
            end else begin : g_rsvd
                assign pend_all[c*NID+i] = 1'b0;
                assign act_all[c*NID+i]  = 1'b0;
            end
        end

        irqd_arbiter #(.NID(NID), .PRIO_W(PRIO_W)) u_arb (
            .pend(pend_all[c*NID +: NID]),
            .act(act_all[c*NID +: NID]),
            .prio(prio_flat),
            .offer_id(offer_id),
            .offer_valid(offer_valid));

        assign ack_id[c*ID_OUT_W +: ID_OUT_W] = offer_id;
        assign irq_out[c] = offer_valid;
    end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NID  = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCPU-1:0]            ack,
    input logic [NCPU-1:0]            eoi,
    input logic [NCPU*ID_OUT_W-1:0]   ack_id,
    input logic [NCPU*ID_OUT_W-1:0]   eoi_id,
    input logic [NCPU-1:0]            irq_out,
    input logic [NCPU*NID-1:0]        pend,
    input logic [NCPU*NID-1:0]        act,
    input logic [NID-1:0]             en
);
    for (genvar c = 0; c < NCPU; c++) begin : g_c
        for (genvar i = 0; i < NID; i++) begin : g_i
            AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
                ack[c] && irq_out[c] && ack_id[c*ID_OUT_W +: ID_OUT_W] == ID_OUT_W'(i)
                |=> act[c*NID+i]); // R8
            AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[c] && ack_id[c*ID_OUT_W +: ID_OUT_W] == ID_OUT_W'(i)
                |-> pend[c*NID+i]); // R8
            AST_EOI_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
                eoi[c] && eoi_id[c*ID_OUT_W +: ID_OUT_W] == ID_OUT_W'(i) && act[c*NID+i]
                |=> !act[c*NID+i]); // R10
            AST_DISABLED_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
                !en[i] && !pend[c*NID+i] && !act[c*NID+i]
                |=> !pend[c*NID+i]); // R3
        end
    end
endmodule

bind irq_distributor irqd_checker #(.NCPU(NCPU), .NID(NID)) u_irqd_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi),
    .ack_id(ack_id), .eoi_id(eoi_id), .irq_out(irq_out),
    .pend(pend_all), .act(act_all), .en(en_q)
);

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
    localparam int NCPU = 4;
    localparam int NHW  = 32;
    localparam int NID  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NHW-1:0]  hw_irq = '0;
    logic [NCPU-1:0] tmr_irq = '0, wdg_irq = '0, fiq_in = '0, ack = '0, eoi = '0;
    logic [NCPU-1:0] fiq_out, irq_out;
    logic            cfg_wr = 1'b0;
    logic [1:0]      cfg_kind = '0;
    logic [1:0]      cfg_cpu = '0;
    logic [5:0]      cfg_id = '0;
    logic [5:0]      cfg_data = '0;
    logic [NCPU*10-1:0] ack_id;
    logic [NCPU*10-1:0] eoi_id = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_distributor #(.NCPU(NCPU), .NHW(NHW), .PRIO_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .tmr_irq(tmr_irq),
        .wdg_irq(wdg_irq), .fiq_in(fiq_in), .fiq_out(fiq_out),
        .cfg_wr(cfg_wr), .cfg_kind(cfg_kind), .cfg_cpu(cfg_cpu),
        .cfg_id(cfg_id), .cfg_data(cfg_data), .ack(ack), .ack_id(ack_id),
        .irq_out(irq_out), .eoi(eoi), .eoi_id(eoi_id));

    // behavioural reference model: 0 inactive, 1 pending, 2 active
    int st  [NCPU][NID];
    int nst [NCPU][NID];
    int mpr [NCPU][NID];
    bit men [NID];
    bit [NCPU-1:0] mtg [NHW];
    int moff [NCPU];

    function automatic int mbest(int c);
        int bp = 99, bid = -1, run = 16;
        for (int i = 0; i < NID; i++) begin
            if (st[c][i] == 1 && mpr[c][i] < bp) begin bp = mpr[c][i]; bid = i; end
            if (st[c][i] == 2 && mpr[c][i] < run) run = mpr[c][i];
        end
        return (bid >= 0 && bp < run) ? bid : 1023;
    endfunction

    function automatic bit mlevel(int i);
        return (i == 29 || i == 30 || i >= 32);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++)
                for (int i = 0; i < NID; i++) begin st[c][i] = 0; mpr[c][i] = 0; end
            for (int i = 0; i < NID; i++) men[i] = 0;
            for (int h = 0; h < NHW; h++) mtg[h] = '0;
        end else begin
            bit [NCPU-1:0] dest;
            bit fire;
            fire = cfg_wr && cfg_kind == 2'd3 && cfg_id < 16;
            case (cfg_data[5:4])
                2'd0: dest = cfg_data[3:0];
                2'd1: dest = ~(4'b1 << cfg_cpu);
                2'd2: dest = 4'b1 << cfg_cpu;
                default: dest = '0;
            endcase
            for (int c = 0; c < NCPU; c++) moff[c] = mbest(c);
            for (int c = 0; c < NCPU; c++) begin
                for (int i = 0; i < NID; i++) begin
                    bit line, evt, take, ret, valid;
                    valid = (i < 16) || i == 29 || i == 30 || i >= 32;
                    line = (i == 29) ? tmr_irq[c] : (i == 30) ? wdg_irq[c] :
                           (i >= 32) ? (hw_irq[i-32] && mtg[i-32][c]) : 1'b0;
                    evt  = fire && dest[c] && cfg_id == i;
                    take = ack[c] && moff[c] == i;
                    ret  = eoi[c] && int'(eoi_id[c*10 +: 10]) == i;
                    nst[c][i] = st[c][i];
                    if (valid) begin
                        if (st[c][i] == 0) begin
                            if (men[i] && (line || evt)) nst[c][i] = 1;
                        end else if (st[c][i] == 1) begin
                            if (take) nst[c][i] = 2;
                            else if (mlevel(i) && !line) nst[c][i] = 0;
                        end else if (ret) begin
                            nst[c][i] = (mlevel(i) && line && men[i]) ? 1 : 0;
                        end
                    end
                end
            end
            for (int c = 0; c < NCPU; c++)
                for (int i = 0; i < NID; i++) st[c][i] = nst[c][i];
            if (cfg_wr) begin
                case (cfg_kind)
                    2'd0: men[cfg_id] = cfg_data[0];
                    2'd1: for (int c = 0; c < NCPU; c++)
                              if (cfg_id >= 32 || c == cfg_cpu) mpr[c][cfg_id] = cfg_data[3:0];
                    2'd2: if (cfg_id >= 32) mtg[cfg_id-32] = cfg_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int aid(int c);
        return int'(ack_id[c*10 +: 10]);
    endfunction

    // per-cycle comparison against the model (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCPU; c++) begin
                int e;
                e = mbest(c);
                chk(aid(c) == e, "R8 model ack_id", aid(c), e);
                chk(irq_out[c] == (e != 1023), "R8 model irq_out", irq_out[c], (e != 1023));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #2;
    endtask

    task automatic wr(int kind, int cpu, int id, int data);
        cfg_wr = 1'b1; cfg_kind = 2'(kind); cfg_cpu = 2'(cpu);
        cfg_id = 6'(id); cfg_data = 6'(data);
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic ack_pulse(int c);
        ack[c] = 1'b1; tick(); ack[c] = 1'b0;
    endtask

    task automatic eoi_pulse(int c, int id);
        eoi[c] = 1'b1; eoi_id[c*10 +: 10] = 10'(id); tick(); eoi[c] = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        rst_n = 1'b1;
        #1;
        for (int c = 0; c < NCPU; c++) begin
            chk(aid(c) == 1023, "R1 reset ack_id", aid(c), 1023);
            chk(irq_out[c] == 1'b0, "R1 reset irq_out", irq_out[c], 0);
        end

        // R12 R5: shared line 40 to CPUs 1 and 2
        wr(1, 0, 40, 5);
        wr(2, 0, 40, 6'b000110);
        wr(0, 0, 40, 1);
        hw_irq[8] = 1'b1; tick();
        chk(aid(1) == 40, "R5 cpu1 routed", aid(1), 40);
        chk(aid(2) == 40, "R5 cpu2 routed", aid(2), 40);
        chk(aid(0) == 1023, "R5 cpu0 not routed", aid(0), 1023);
        chk(aid(3) == 1023, "R5 cpu3 not routed", aid(3), 1023);

        // R3: disabled, then enable written in the sampling cycle
        wr(2, 0, 41, 6'b001000);
        hw_irq[9] = 1'b1; tick();
        chk(aid(3) == 1023, "R3 disabled stays idle", aid(3), 1023);
        wr(0, 0, 41, 1);
        chk(aid(3) == 1023, "R3 same-cycle enable not yet", aid(3), 1023);
        tick();
        chk(aid(3) == 41, "R3 enable takes effect", aid(3), 41);

        // R2: private timer on CPU0 only
        tmr_irq[0] = 1'b1;
        wr(0, 0, 29, 1);
        tick();
        chk(aid(0) == 29, "R2 timer id on cpu0", aid(0), 29);
        chk(aid(1) == 40, "R2 timer private", aid(1), 40);

        // R6 R7: software interrupt 3 to all but CPU2, banked priority
        wr(0, 0, 3, 1);
        wr(1, 0, 3, 2);
        wr(3, 2, 3, 6'b010000);
        chk(aid(1) == 3, "R7 cpu1 bank prio 0", aid(1), 3);
        chk(aid(0) == 29, "R7 cpu0 bank prio 2", aid(0), 29);
        chk(aid(3) == 3, "R7 tie lower id", aid(3), 3);
        chk(aid(2) == 40, "R6 others excludes self", aid(2), 40);

        // R8 R10: take and complete
        ack_pulse(1);
        chk(aid(1) == 1023, "R8 running prio blocks", aid(1), 1023);
        eoi_pulse(1, 7);
        chk(aid(1) == 1023, "R10 eoi non-active ignored", aid(1), 1023);
        eoi_pulse(1, 3);
        chk(aid(1) == 40, "R10 retire", aid(1), 40);

        // R9: preemption
        ack_pulse(2);
        chk(aid(2) == 1023, "R8 after take", aid(2), 1023);
        wr(1, 0, 44, 5); wr(2, 0, 44, 6'b000100); wr(0, 0, 44, 1);
        hw_irq[12] = 1'b1; tick(); tick();
        chk(aid(2) == 1023, "R9 equal prio no preempt", aid(2), 1023);
        wr(1, 0, 42, 3); wr(2, 0, 42, 6'b000100); wr(0, 0, 42, 1);
        hw_irq[10] = 1'b1; tick();
        chk(aid(2) == 42, "R9 preempt", aid(2), 42);

        // R4 R10: withdraw and repend
        hw_irq[10] = 1'b0; hw_irq[12] = 1'b0; tick();
        chk(aid(2) == 1023, "R4 withdraw", aid(2), 1023);
        eoi_pulse(2, 40);
        chk(aid(2) == 40, "R10 repend while asserted", aid(2), 40);
        hw_irq[8] = 1'b0; tick();
        chk(aid(1) == 1023, "R4 withdraw cpu1", aid(1), 1023);
        chk(aid(2) == 1023, "R4 withdraw cpu2", aid(2), 1023);

        // R6: self, list, none
        wr(0, 0, 1, 1);
        wr(3, 0, 1, 6'b100000);
        chk(aid(0) == 1, "R6 self", aid(0), 1);
        chk(aid(1) == 1023, "R6 self only", aid(1), 1023);
        wr(3, 0, 1, 6'b000010);
        chk(aid(1) == 1, "R6 list", aid(1), 1);
        chk(aid(2) == 1023, "R6 list excludes", aid(2), 1023);
        wr(3, 1, 1, 6'b110100);
        chk(aid(2) == 1023, "R6 none", aid(2), 1023);

        // R11
        fiq_in = 4'b1010; #1;
        chk(fiq_out == 4'b1010, "R11 fiq pass", fiq_out, 4'b1010);
        fiq_in = 4'b0101; #1;
        chk(fiq_out == 4'b0101, "R11 fiq pass", fiq_out, 4'b0101);

        // random phase, compared against the model every cycle
        for (int n = 0; n < 400; n++) begin
            hw_irq  = $urandom;
            tmr_irq = 4'($urandom);
            wdg_irq = 4'($urandom);
            ack     = 4'($urandom) & 4'($urandom);
            eoi     = 4'($urandom) & 4'($urandom);
            for (int c = 0; c < NCPU; c++) begin
                int pick;
                pick = $urandom % 4;
                eoi_id[c*10 +: 10] = (pick == 0) ? 10'($urandom % 64) :
                                     (pick == 1) ? 10'(1023) : ack_id[c*10 +: 10];
            end
            cfg_wr   = ($urandom % 3) == 0;
            cfg_kind = 2'($urandom);
            cfg_cpu  = 2'($urandom);
            cfg_id   = 6'($urandom);
            cfg_data = 6'($urandom);
            tick();
        end
        cfg_wr = 1'b0; ack = '0; eoi = '0;
        tick();
        summary();
    end
endmodule